// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gathers four interrupt sources into one registered request line. Each source has a pending bit and an enable bit. A pending bit is captured on a rising edge of its source, but only while that source is enabled. The request line is high while any pending bit is also enabled. Software clears pending bits by writing ones to the status word.

Software never writes the enable mask directly. It writes ones to a word that turns bits on, or ones to another word that turns bits off. Two agents can therefore change different enables without a read-modify-write sequence that might lose one of the updates. The current mask is visible through a read-only word.

The bus is word-addressed, with a 2-bit address, a write strobe with 32-bit write data, and a read strobe. Read data is combinational and valid in the cycle the read strobe is high. Source `irq_src[i]` always maps to mask and status bit `i`. In the intended use, bit 0 is the first slot's trigger, bit 1 is the first slot's acquisition end, bit 2 is the second slot's trigger and bit 3 is the second slot's acquisition end.

Top module: `irqc_setclr`

## Requirements
- R1: While `rst_n` is low (asynchronous), and after reset is released, the mask is 0000, every pending bit is 0 and `irq_o` is 0.
- R2: A write to word address 1 (mask-on) sets mask bit i for every 1 in write-data bit i. A 0 in any data bit leaves that mask bit unchanged. The new mask is readable after the clock edge that takes the write.
- R3: A write to word address 0 (mask-off) clears mask bit i for every 1 in write-data bit i. A 0 in any data bit leaves that mask bit unchanged.
- R4: A read of word address 2 returns the mask in bits [3:0], with bits [31:4] equal to zero. A write to address 2 changes nothing.
- R5: A read of word address 0 or 1 returns zero.
- R6: Pending bit i becomes 1 at the clock edge where `irq_src[i]` is high and was low at the previous edge, provided mask bit i is 1. An edge on a masked source is not recorded. A source held high does not set its bit again. The pending bits are read at word address 3, in bits [3:0].
- R7: A write to word address 3 clears pending bit i for every 1 in write-data bit i. A 0 in any data bit leaves that pending bit unchanged.
- R8: If a new rising edge and a clearing write hit the same pending bit at the same clock edge, the bit is left set.
- R9: `irq_o` is a register that takes the OR of (pending AND mask) one clock edge later. Clearing the mask bit therefore lowers `irq_o` while the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_src | input | 4 | Interrupt sources, edge-captured |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that mask bits move only in response to a mask-on or mask-off write, and move in the direction written. They also check that a pending bit never appears while its enable is off, that a clearing write wins only when no edge arrives at the same time, and that `irq_o` rises and falls only after the enabled pending set changes. The bench scenarios show the remaining behaviour: the exact read values at each address, that a held source level does not re-capture, the one-cycle lag of `irq_o` after a mask change, and the same-edge race between a clear and a new edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK_OFF = 2'd0,
        SEL_MASK_ON  = 2'd1,
        SEL_MASK_RD  = 2'd2,
        SEL_PENDING  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic [N_SRC-1:0]  mask,
    input  logic [N_SRC-1:0]  pending,
    output logic [N_SRC-1:0]  on_vec,
    output logic [N_SRC-1:0]  off_vec,
    output logic [N_SRC-1:0]  ack_vec,
    output logic [DATA_W-1:0] rdata
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:N_SRC];

    always_comb begin
        on_vec  = '0;
        off_vec = '0;
        ack_vec = '0;
        if (wr) begin
            case (reg_sel_e'(addr))
                SEL_MASK_OFF: off_vec = wdata[N_SRC-1:0];
                SEL_MASK_ON:  on_vec  = wdata[N_SRC-1:0];
                SEL_PENDING:  ack_vec = wdata[N_SRC-1:0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (reg_sel_e'(addr))
                SEL_MASK_RD: rdata[N_SRC-1:0] = mask;
                SEL_PENDING: rdata[N_SRC-1:0] = pending;
                default:     ;
            endcase
        end
    end

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr == SEL_MASK_OFF || addr == SEL_MASK_ON)) |-> (rdata == '0)); // R5
    AST_MASK_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SEL_MASK_RD) |-> (on_vec == '0 && off_vec == '0 && ack_vec == '0)); // R4
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] on_vec,
    input  logic [N_SRC-1:0] off_vec,
    output logic [N_SRC-1:0] mask
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | on_vec) & ~off_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.en;

    AST_MASK_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask & $past(on_vec & ~off_vec)) == $past(on_vec & ~off_vec))); // R2
    AST_MASK_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask & $past(off_vec)) == '0)); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (on_vec == '0 && off_vec == '0) |=> $stable(mask)); // R4
endmodule

// File: rtl/irqc_pending_bank.sv
module irqc_pending_bank #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] ack_vec,
    output logic [N_SRC-1:0] pending
);
    typedef struct packed {
        logic [N_SRC-1:0] src_prev;
        logic [N_SRC-1:0] hit;
    } pend_state_t;

    pend_state_t      st_d, st_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        rise          = src & ~st_q.src_prev;
        st_d          = st_q;
        st_d.src_prev = src;
        st_d.hit      = (st_q.hit & ~ack_vec) | (rise & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.hit;

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(mask)) == '0)); // R6
    AST_PEND_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(ack_vec) & ~$past(src)) == '0)); // R7
    AST_PEND_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(src & ~st_q.src_prev & mask) & ~pending) == '0)); // R8
endmodule

// File: rtl/irqc_setclr.sv
module irqc_setclr
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  irq_src,
    output logic              irq_o
);
    typedef struct packed {
        logic req;
    } top_state_t;

    logic [N_SRC-1:0] mask, pending, on_vec, off_vec, ack_vec;
    top_state_t       st_d, st_q;

    irqc_decode #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .rd      (bus_rd),
        .mask    (mask),
        .pending (pending),
        .on_vec  (on_vec),
        .off_vec (off_vec),
        .ack_vec (ack_vec),
        .rdata   (bus_rdata)
    );

    irqc_mask_bank #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_vec  (on_vec),
        .off_vec (off_vec),
        .mask    (mask)
    );

    irqc_pending_bank #(.N_SRC(N_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (irq_src),
        .mask    (mask),
        .ack_vec (ack_vec),
        .pending (pending)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = |(pending & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.req;

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past((pending & mask) == '0)); // R9
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((pending & mask) != '0)); // R9
endmodule

// File: tb/tb_irqc_setclr.sv
module tb_irqc_setclr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_src = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irqc_setclr dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .irq_o     (irq_o)
    );

    // word addresses: 0 mask-off, 1 mask-on, 2 mask read, 3 pending
    typedef struct packed {
        logic       rd;
        logic [1:0] addr;
        logic [3:0] data;
        logic [3:0] src;
        logic [3:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 4'h0, 4'h0, 4'h0, 4'd1},  // R1 mask zero after reset
        '{1'b1, 2'd3, 4'h0, 4'h0, 4'h0, 4'd1},  // R1 pending zero after reset
        '{1'b0, 2'd1, 4'h5, 4'h0, 4'h0, 4'd2},  // R2 turn on bits 0,2
        '{1'b1, 2'd2, 4'h0, 4'h0, 4'h5, 4'd2},
        '{1'b0, 2'd1, 4'h2, 4'h0, 4'h0, 4'd2},  // R2 zeros leave bits alone
        '{1'b1, 2'd2, 4'h0, 4'h0, 4'h7, 4'd2},
        '{1'b0, 2'd0, 4'h1, 4'h0, 4'h0, 4'd3},  // R3 turn off bit 0
        '{1'b1, 2'd2, 4'h0, 4'h0, 4'h6, 4'd3},
        '{1'b0, 2'd2, 4'hF, 4'h0, 4'h0, 4'd4},  // R4 write to read-only word
        '{1'b1, 2'd2, 4'h0, 4'h0, 4'h6, 4'd4},
        '{1'b1, 2'd1, 4'h0, 4'h0, 4'h0, 4'd5},  // R5 mask-on reads zero
        '{1'b1, 2'd0, 4'h0, 4'h0, 4'h0, 4'd5},  // R5 mask-off reads zero
        '{1'b1, 2'd3, 4'h0, 4'hF, 4'h0, 4'd6},  // R6 edges arrive now
        '{1'b1, 2'd3, 4'h0, 4'hF, 4'h6, 4'd6},  // R6 only enabled bits captured
        '{1'b0, 2'd3, 4'h2, 4'hF, 4'h0, 4'd7},  // R7 clear bit 1
        '{1'b1, 2'd3, 4'h0, 4'hF, 4'h4, 4'd7},  // R7 held level does not recapture
        '{1'b0, 2'd3, 4'h0, 4'hF, 4'h0, 4'd7},  // R7 zero write
        '{1'b1, 2'd3, 4'h0, 4'hF, 4'h4, 4'd7}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rd_word(2'd2, v); check("R1", "mask in reset", v, 32'h0);
        rd_word(2'd3, v); check("R1", "pending in reset", v, 32'h0);
        check("R1", "irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            irq_src = VEC[i].src;
            bus_addr = VEC[i].addr;
            if (VEC[i].rd) begin
                bus_rd = 1'b1;
                #1;
                checks++;
                if (bus_rdata !== {28'b0, VEC[i].exp}) begin
                    fails++;
                    $display("FAIL R%0d row %0d: actual %h expected %h",
                             VEC[i].req, i, bus_rdata, {28'b0, VEC[i].exp});
                end
            end else begin
                bus_wdata = {28'b0, VEC[i].data};
                bus_wr = 1'b1;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;

        // pending 0100, mask 0110
        check("R9", "irq with enabled pending", {31'b0, irq_o}, 32'h1);
        wr_word(2'd0, 32'h4);
        check("R9", "irq one edge after mask-off", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R9", "irq after mask-off", {31'b0, irq_o}, 32'h0);
        rd_word(2'd3, v); check("R9", "pending kept when masked", v, 32'h4);
        wr_word(2'd1, 32'h4);
        @(negedge clk);
        check("R9", "irq after mask-on", {31'b0, irq_o}, 32'h1);
        wr_word(2'd3, 32'h4);
        rd_word(2'd3, v); check("R7", "pending after clear", v, 32'h0);
        @(negedge clk);
        check("R9", "irq after clear", {31'b0, irq_o}, 32'h0);

        // edge and clear on the same bit at the same edge
        irq_src = 4'h0;
        @(negedge clk);
        irq_src = 4'h2;
        @(negedge clk);
        rd_word(2'd3, v); check("R6", "edge captured", v, 32'h2);
        irq_src = 4'h0;
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 32'h2; bus_wr = 1'b1; irq_src = 4'h2;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_word(2'd3, v); check("R8", "edge beats clear", v, 32'h2);

        // asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        rd_word(2'd2, v); check("R1", "mask after reset", v, 32'h0);
        rd_word(2'd3, v); check("R1", "pending after reset", v, 32'h0);
        check("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule